// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital control for a successive-approximation converter. Each conversion runs through three phases in a fixed order. The first is a fixed precharge interval. The second is an acquisition window whose length software sets. The third is a 16-step binary search, during which the block drives a trial code to the capacitive DAC and reads back one comparator bit per step, starting at the most significant bit. When the search ends, the block writes the result register and raises a one-cycle done pulse.

A 32-bit configuration word holds two settings. Bits 25:16 give the acquisition length in clock cycles. Bits 9:0 give the minimum spacing, in cycles, between the starts of consecutive conversions in continuous mode. A conversion can be started in three ways:
- a software single-shot pulse;
- a software continuous-mode level;
- rising edges on an external trigger pin, which first passes through a synchronizer.

A differential/single-ended select is captured at the start of each conversion and held for the analog front end until the conversion ends.

Top module: `sar_conv_seq`

## Requirements
- R1: While reset is asserted and just after it is released, `busy_o`, `done_o`, `pre_o`, `acq_o` and `cnv_o` are low and `result_o` is zero.
- R2: When a start is accepted, the phases follow in order with no gaps. `pre_o` is high for exactly 4 cycles, then `acq_o` is high, then `cnv_o` is high for exactly 16 cycles. At most one phase output is high in any cycle, and `pre_o` rises on the cycle after the cycle in which the start was accepted.
- R3: `acq_o` stays high for the number of cycles given by `cfg_word[25:16]`. A setting of 0 is treated as 1.
- R4: In the first conversion cycle `sar_dac_o` is 16'h8000. Each cycle adds the next lower bit to the trial code. `cmp_i`=1 means the input is at or above the trial code, and that bit is kept. The final result is therefore the largest code that the comparator accepts.
- R5: `done_o` is high for exactly one cycle, in the cycle after the last `cnv_o` cycle. `result_o` changes only together with `done_o`. `busy_o` is high from the first precharge cycle through the last conversion cycle and is low when `done_o` is high. From a single request, `done_o` therefore comes 20 + acquisition-length cycles after the first `pre_o` cycle.
- R6: While `sw_cont` is high, conversions repeat. The spacing between successive `pre_o` rises is the larger of `cfg_word[9:0]` and the acquisition length plus 21 cycles.
- R7: When `ext_trig_en` is high, a rising edge on `ext_trig_pin` starts a conversion. `pre_o` rises on the third clock edge after the pin rises. When `ext_trig_en` is low, the pin has no effect.
- R8: A single-shot request or an external rising edge that arrives while `busy_o` is high is ignored. It is neither queued nor started later.
- R9: `diff_mode_o` takes the value of `diff_mode_i` when a conversion starts and holds it while `busy_o` is high.
- R10: After `sw_cont` goes low, the conversion in progress completes and no new conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock (20 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Configuration: [25:16] acquisition cycles, [9:0] continuous-mode period |
| diff_mode_i | input | 1 | 1 = differential input, 0 = single-ended |
| sw_single | input | 1 | One-cycle software request for one conversion |
| sw_cont | input | 1 | Level: repeat conversions while high |
| ext_trig_en | input | 1 | Enables the external trigger pin |
| ext_trig_pin | input | 1 | Asynchronous external trigger, rising-edge active |
| cmp_i | input | 1 | Comparator decision: input at or above trial code |
| pre_o | output | 1 | Precharge phase active |
| acq_o | output | 1 | Acquisition phase active (sampling switches closed) |
| cnv_o | output | 1 | Conversion phase active (sampling switches open) |
| busy_o | output | 1 | A conversion is in progress |
| done_o | output | 1 | One-cycle pulse when a result is written |
| diff_mode_o | output | 1 | Input mode held for the current conversion |
| sar_dac_o | output | 16 | Trial code driven to the capacitive DAC |
| result_o | output | 16 | Last conversion result |

## Verification
The bench builds the block with its default parameters: 16-bit resolution, a 4-cycle precharge and a 2-stage trigger synchronizer. It varies the acquisition field over 0, 1, 2, 5, 10, 12 and 30, which includes the zero-means-one boundary and both nominal settings. It sets the period field to 100, 24, 23 and 5, so that both the case where the period governs and the case where the phase length governs are reached, as well as the exact tie between them. Its model comparator answers against a fixed threshold. The search result is therefore known in advance, including all-zeros, all-ones and half-scale neighbours.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_ACQ  = 2'd2,
    PH_CONV = 2'd3
  } phase_e;
endpackage

// File: rtl/sar_trig_sync.sv
module sar_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  // synchronizer chain, one flop per stage
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign sync_d[s] = pin_i;
    end else begin : g_next
      assign sync_d[s] = sync_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/sar_rate_timer.sv
module sar_rate_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] period_i,
  output logic         elapsed_o
);
  logic [W-1:0] since_q;
  logic [W-1:0] since_d;

  always_comb begin
    since_d = since_q;
    if (start_i) begin
      since_d = W'(1);
    end else if (since_q != {W{1'b1}}) begin
      since_d = since_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_q <= {W{1'b1}};
    else        since_q <= since_d;
  end

  assign elapsed_o = (since_q >= period_i);
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int W     = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             last_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             cmp_i,
  output logic [W-1:0]     trial_o,
  output logic [W-1:0]     result_o,
  output logic             done_o
);
  logic [W-1:0] acc_q, acc_d;
  logic [W-1:0] res_q, res_d;
  logic         done_q, done_d;
  logic [W-1:0] mask;

  assign mask    = W'(1) << idx_i;
  assign trial_o = acc_q | mask;

  always_comb begin
    acc_d  = acc_q;
    res_d  = res_q;
    done_d = step_i & last_i;
    if (clr_i) begin
      acc_d = '0;
    end else if (step_i && cmp_i) begin
      acc_d = trial_o;
    end
    if (step_i && last_i) begin
      res_d = cmp_i ? trial_o : acc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      res_q  <= res_d;
      done_q <= done_d;
    end
  end

  assign result_o = res_q;
  assign done_o   = done_q;
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int RES_W       = 16,
  parameter int CFG_W       = 32,
  parameter int ACQ_LSB     = 16,
  parameter int ACQ_W       = 10,
  parameter int RATE_LSB    = 0,
  parameter int RATE_W      = 10,
  parameter int PRE_CYC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             diff_mode_i,
  input  logic             sw_single,
  input  logic             sw_cont,
  input  logic             ext_trig_en,
  input  logic             ext_trig_pin,
  input  logic             cmp_i,
  output logic             pre_o,
  output logic             acq_o,
  output logic             cnv_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             diff_mode_o,
  output logic [RES_W-1:0] sar_dac_o,
  output logic [RES_W-1:0] result_o
);
  import sar_seq_pkg::*;

  localparam int IDX_W = $clog2(RES_W);
  localparam int CNT_W = (ACQ_W > IDX_W + 1) ? ACQ_W : IDX_W + 1;

  phase_e            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              mode_q, mode_d;
  logic [ACQ_W-1:0]  acq_raw, acq_len;
  logic [RATE_W-1:0] period;
  logic              ext_rise, period_ok, start;
  logic              conv_step, conv_last;
  logic [IDX_W-1:0]  bit_idx;
  logic              unused_cfg_bits;

  assign acq_raw = cfg_word[ACQ_LSB +: ACQ_W];
  assign acq_len = (acq_raw == '0) ? ACQ_W'(1) : acq_raw;
  assign period  = cfg_word[RATE_LSB +: RATE_W];
  assign unused_cfg_bits = ^{cfg_word};

  sar_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (ext_trig_pin),
    .rise_o (ext_rise)
  );

  sar_rate_timer #(.W(RATE_W)) u_rate (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .period_i  (period),
    .elapsed_o (period_ok)
  );

  assign start = (ph_q == PH_IDLE) &&
                 (sw_single || (sw_cont && period_ok) || (ext_trig_en && ext_rise));

  // next-state process
  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d   = PH_PRE;
          cnt_d  = '0;
          mode_d = diff_mode_i;
        end
      end
      PH_PRE: begin
        if (cnt_q == CNT_W'(PRE_CYC - 1)) begin
          ph_d  = PH_ACQ;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      PH_ACQ: begin
        if (cnt_q == CNT_W'(acq_len - ACQ_W'(1))) begin
          ph_d  = PH_CONV;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      PH_CONV: begin
        if (conv_last) begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end

  assign conv_step = (ph_q == PH_CONV);
  assign conv_last = conv_step && (cnt_q == CNT_W'(RES_W - 1));
  assign bit_idx   = IDX_W'(RES_W - 1) - cnt_q[IDX_W-1:0];

  sar_approx #(.W(RES_W), .IDX_W(IDX_W)) u_sar (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (ph_q == PH_PRE),
    .step_i   (conv_step),
    .last_i   (conv_last),
    .idx_i    (bit_idx),
    .cmp_i    (cmp_i),
    .trial_o  (sar_dac_o),
    .result_o (result_o),
    .done_o   (done_o)
  );

  assign pre_o       = (ph_q == PH_PRE);
  assign acq_o       = (ph_q == PH_ACQ);
  assign cnv_o       = conv_step;
  assign busy_o      = (ph_q != PH_IDLE);
  assign diff_mode_o = mode_q;
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int RES_W   = 16,
  parameter int PRE_CYC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pre_o,
  input logic             acq_o,
  input logic             cnv_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             diff_mode_o,
  input logic [RES_W-1:0] result_o
);
  logic [7:0] pre_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pre_run_q <= '0;
    else if (pre_o) pre_run_q <= pre_run_q + 8'd1;
    else            pre_run_q <= '0;
  end

  // R2
  phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pre_o, acq_o, cnv_o}));

  // R2
  acq_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_o) |-> $past(pre_o));

  // R2
  cnv_after_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_o) |-> $past(acq_o));

  // R2
  pre_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pre_o) |-> ($past(pre_run_q) == 8'(PRE_CYC - 1)));

  // R5
  done_after_cnv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(cnv_o) && !busy_o));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(diff_mode_o));
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.RES_W(RES_W), .PRE_CYC(PRE_CYC)) u_chk (.*);

// File: tb/sim_sar_conv_seq.sv
module sim_sar_conv_seq;
  logic        clk;
  logic        rst_n;
  logic [31:0] cfg_word;
  logic        diff_mode_i, sw_single, sw_cont, ext_trig_en, ext_trig_pin;
  logic        cmp_i;
  logic        pre_o, acq_o, cnv_o, busy_o, done_o, diff_mode_o;
  logic [15:0] sar_dac_o, result_o;
  logic [15:0] target;

  int total;
  int bad;
  int cyc;

  sar_conv_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .diff_mode_i(diff_mode_i),
    .sw_single(sw_single), .sw_cont(sw_cont), .ext_trig_en(ext_trig_en),
    .ext_trig_pin(ext_trig_pin), .cmp_i(cmp_i), .pre_o(pre_o), .acq_o(acq_o),
    .cnv_o(cnv_o), .busy_o(busy_o), .done_o(done_o), .diff_mode_o(diff_mode_o),
    .sar_dac_o(sar_dac_o), .result_o(result_o)
  );

  // model comparator: input sits at "target"
  assign cmp_i = (sar_dac_o <= target);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // {target[15:0], acq[9:0], diff}
  localparam int NV = 6;
  localparam logic [26:0] VEC [NV] = '{
    {16'h0000, 10'd10, 1'b0},
    {16'hFFFF, 10'd30, 1'b1},
    {16'h8000, 10'd1,  1'b0},
    {16'h7FFF, 10'd0,  1'b1},
    {16'h1234, 10'd5,  1'b0},
    {16'hA5A5, 10'd12, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [15:0] tg, input logic [9:0] a, input logic d);
    int n, npre, nacq, ncnv, lastph, ph, order_bad, aeff;
    logic [15:0] first_dac;
    bit seen;
    n = 0; npre = 0; nacq = 0; ncnv = 0; lastph = 1; order_bad = 0; seen = 0;
    first_dac = '0;
    @(negedge clk);
    target = tg; cfg_word = {6'b0, a, 6'b0, 10'd0}; diff_mode_i = d; sw_single = 1'b1;
    @(negedge clk);
    sw_single = 1'b0;
    while (!done_o && n < 2000) begin
      ph = pre_o ? 1 : acq_o ? 2 : cnv_o ? 3 : 0;
      if (ph < lastph || ph == 0 || $countones({pre_o, acq_o, cnv_o}) > 1) order_bad++;
      if (pre_o) npre++;
      if (acq_o) nacq++;
      if (cnv_o) begin
        ncnv++;
        if (!seen) begin first_dac = sar_dac_o; seen = 1; end
      end
      if (n == 6) diff_mode_i = ~d;
      lastph = ph;
      @(negedge clk);
      n++;
    end
    aeff = (a == 0) ? 1 : int'(a);
    chk("R2 precharge cycles", npre, 4);
    chk("R2 phase order", order_bad, 0);
    chk("R2 conversion cycles", ncnv, 16);
    chk("R3 acquisition cycles", nacq, aeff);
    chk("R4 first trial code", first_dac, 16'h8000);
    chk("R4 result", result_o, tg);
    chk("R5 busy low at done", busy_o, 0);
    chk("R5 done latency", n, 20 + aeff);
    chk("R9 mode held", diff_mode_o, d);
    @(negedge clk);
    chk("R5 done one cycle", done_o, 0);
    diff_mode_i = 1'b0;
  endtask

  task automatic wait_pre_rise(output int t);
    logic was;
    int k;
    was = pre_o;
    k = 0;
    t = -1;
    while (k < 3000) begin
      @(negedge clk);
      if (pre_o && !was) begin t = cyc; break; end
      was = pre_o;
      k++;
    end
  endtask

  task automatic count_events(input int ncyc, output int rises, output int dones);
    logic was;
    rises = 0; dones = 0;
    was = pre_o;
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      if (pre_o && !was) rises++;
      if (done_o) dones++;
      was = pre_o;
    end
  endtask

  task automatic cont_gap(input logic [9:0] p, input logic [9:0] a, input int exp_gap);
    int t1, t2, r, dn, k;
    @(negedge clk);
    target = 16'h4321; cfg_word = {6'b0, a, 6'b0, p}; sw_cont = 1'b1;
    wait_pre_rise(t1);
    wait_pre_rise(t2);
    sw_cont = 1'b0;
    chk("R6 continuous spacing", t2 - t1, exp_gap);
    k = 0;
    while (!done_o && k < 2000) begin @(negedge clk); k++; end
    chk("R6 continuous result", result_o, 16'h4321);
    count_events(150, r, dn);
    chk("R10 no start after continuous off", r, 0);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r, dn;
    total = 0; bad = 0; cyc = 0;
    rst_n = 1'b0; cfg_word = '0; diff_mode_i = 1'b0; sw_single = 1'b0;
    sw_cont = 1'b0; ext_trig_en = 1'b0; ext_trig_pin = 1'b0; target = '0;
    repeat (5) @(negedge clk);
    chk("R1 busy in reset", busy_o, 0);
    chk("R1 result in reset", result_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 phase outputs", {pre_o, acq_o, cnv_o}, 0);
    chk("R1 result", result_o, 0);

    for (int i = 0; i < NV; i++) begin
      run_vec(VEC[i][26:11], VEC[i][10:1], VEC[i][0]);
    end

    // R6 / R10: period-governed, phase-governed and tie cases
    cont_gap(10'd100, 10'd10, 100);
    cont_gap(10'd5,   10'd10, 31);
    cont_gap(10'd24,  10'd2,  24);
    cont_gap(10'd23,  10'd2,  23);

    // R7 external trigger latency
    @(negedge clk);
    cfg_word = {6'b0, 10'd10, 16'd0}; target = 16'h0F0F; ext_trig_en = 1'b1;
    ext_trig_pin = 1'b1;
    @(negedge clk);
    chk("R7 no start after 1 edge", pre_o, 0);
    @(negedge clk);
    chk("R7 no start after 2 edges", pre_o, 0);
    @(negedge clk);
    chk("R7 start after 3 edges", pre_o, 1);
    repeat (2) @(negedge clk);
    ext_trig_pin = 1'b0;
    repeat (4) @(negedge clk);
    // R8: second edge while busy
    ext_trig_pin = 1'b1;
    count_events(150, r, dn);
    chk("R8 external edge while busy ignored", dn, 1);
    chk("R7 trigger result", result_o, 16'h0F0F);
    ext_trig_pin = 1'b0;
    repeat (5) @(negedge clk);

    // R7 disabled pin has no effect
    ext_trig_en = 1'b0;
    ext_trig_pin = 1'b1;
    count_events(100, r, dn);
    chk("R7 disabled trigger ignored", r, 0);
    ext_trig_pin = 1'b0;
    repeat (5) @(negedge clk);

    // R8 single request while busy
    sw_single = 1'b1;
    @(negedge clk);
    sw_single = 1'b0;
    repeat (8) @(negedge clk);
    sw_single = 1'b1;
    @(negedge clk);
    sw_single = 1'b0;
    count_events(150, r, dn);
    chk("R8 single while busy ignored", dn, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule